// File: doc/BRIEF.md
# Dimension-Ordered Mesh Router with Output Hardwall

This block is the switch at one tile of a two-dimensional mesh packet network. It has five 32-bit ports: one toward each neighbour (north, east, south, west) and one to the local processor. Every incoming direction feeds its own small word queue. The first word of each packet is a header that carries the destination column, the destination row and the number of body words. The router routes each packet without any setup. It first moves the packet along X until the column matches, then along Y until the row matches. When both match, it delivers the packet to the local port.

Switching is wormhole. Once a header wins an output, that output stays bound to the same input until the packet's final word has left. Inputs that compete for a free output are served in round-robin order. Each port uses a valid/ready handshake, and a word moves on a clock edge where both are high.

Software controls a five-bit permission mask, with one bit per output. A packet whose route lands on a forbidden output is never forwarded. The router drains it from its queue and discards it. It then raises a one-cycle interrupt and keeps the header and the input index in status outputs, so the processor can see what was stopped. The input is never stalled by a forbidden packet.

Top module: `mesh_router`

## Requirements
- R1: While reset is high, every `in_ready` bit is 1, every `out_valid` bit is 0 and `hw_irq` is 0.
- R2: Header layout: bits [7:0] give the body length in words (0 to 255), bits [19:16] give the destination X and bits [23:20] give the destination Y. Bits [15:8] and [31:24] do not affect routing and are forwarded unchanged.
- R3: A header whose destination X is greater than the tile X leaves on east (port 2). One whose destination X is smaller leaves on west (port 4). Port numbering: 0 local, 1 north, 2 east, 3 south, 4 west.
- R4: When destination X equals the tile X, a larger destination Y leaves on north (port 1), a smaller one leaves on south (port 3), and an equal one leaves on local (port 0).
- R5: A forwarded packet leaves on exactly one output with all words unmodified and in order. No word of another packet appears on that output between its header and its last word.
- R6: Each input queue holds QDEPTH words. When it is full, `in_ready` for that port is low. No word is lost or duplicated while outputs are held not ready.
- R7: Inputs waiting for the same free output are granted round-robin. With two inputs each holding back-to-back single-word packets, the output alternates between them.
- R8: If mask bit `hw_mask[o]` is 0, no word of a packet routed to output o appears on any output.
- R9: For every such blocked packet, `hw_irq` is high for exactly one cycle, in the cycle after its header leaves the queue. `hw_hdr` and `hw_src` then hold that header and the input port index until the next blocked packet.
- R10: A blocked packet is drained from its queue, and packets queued behind it on the same input are then delivered normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tile_x | input | 4 | Column of this tile |
| tile_y | input | 4 | Row of this tile |
| hw_mask | input | 5 | Per-output permission, 1 = traffic may leave |
| in_valid | input | 5 | Word offered on each input port |
| in_data | input | 160 | Input words, port p in bits [32p+31:32p] |
| in_ready | output | 5 | Input queue can accept a word |
| out_valid | output | 5 | Word offered on each output port |
| out_data | output | 160 | Output words, port p in bits [32p+31:32p] |
| out_ready | input | 5 | Downstream accepts the word |
| hw_irq | output | 1 | One-cycle pulse per blocked packet |
| hw_hdr | output | 32 | Header of the most recent blocked packet |
| hw_src | output | 3 | Input port of the most recent blocked packet |

## Verification
Two conditions are hard to reach from the ports. One is real contention for a single output, where several queued packets sit ready at the same time. The other is a wormhole path that holds an output while its owner's queue runs dry. The stimulus holds every `out_ready` low while two inputs load short packets to the local port, then releases the outputs, so the arbiter sees both requests at once. Long packets under random output stalls keep bound paths waiting on empty queues. The hardwall cases change the mask only while the network is idle. They place a blocked packet directly ahead of an allowed one on the same input, so a stuck drain shows up as a missing delivery.

// File: rtl/mesh_rtr_pkg.sv
package mesh_rtr_pkg;

    localparam int NPORT   = 5;
    localparam int WORD_W  = 32;
    localparam int COORD_W = 4;
    localparam int LEN_W   = 8;
    localparam int DX_LSB  = 16;
    localparam int DY_LSB  = DX_LSB + COORD_W;
    localparam int PW      = $clog2(NPORT);
    localparam int RSV_W   = DX_LSB - LEN_W;
    localparam int TAG_W   = WORD_W - DY_LSB - COORD_W;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [COORD_W-1:0] coord_t;
    typedef logic [LEN_W-1:0]   len_t;

    // Port numbering is shared by routing, mask bits and status index
    typedef enum logic [PW-1:0] {
        P_LOCAL = 3'd0,
        P_NORTH = 3'd1,
        P_EAST  = 3'd2,
        P_SOUTH = 3'd3,
        P_WEST  = 3'd4
    } port_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        coord_t           dy;
        coord_t           dx;
        logic [RSV_W-1:0] rsv;
        len_t             len;
    } hdr_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_FWD  = 2'd1,
        S_DROP = 2'd2
    } ictl_e;

    // X first, then Y, then local
    function automatic port_e xy_route(input hdr_t h, input coord_t mx, input coord_t my);
        port_e r;
        if (h.dx > mx)      r = P_EAST;
        else if (h.dx < mx) r = P_WEST;
        else if (h.dy > my) r = P_NORTH;
        else if (h.dy < my) r = P_SOUTH;
        else                r = P_LOCAL;
        return r;
    endfunction

    // First requester after the last winner, wrapping around
    function automatic logic [NPORT-1:0] rr_pick(input logic [NPORT-1:0] req,
                                                 input logic [PW-1:0]    last);
        logic [NPORT-1:0] g;
        logic [PW-1:0]    ix;
        g = '0;
        for (int k = NPORT; k >= 1; k--) begin
            ix = PW'((int'(last) + k) % NPORT);
            if (req[ix]) begin
                g     = '0;
                g[ix] = 1'b1;
            end
        end
        return g;
    endfunction

    function automatic logic [PW-1:0] oh_index(input logic [NPORT-1:0] oh);
        logic [PW-1:0] r;
        r = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (oh[i]) r = PW'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/mesh_rtr_fifo.sv
module mesh_rtr_fifo
    import mesh_rtr_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  word_t wr_data,
    input  logic  rd_en,
    output word_t rd_data,
    output logic  empty,
    output logic  full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    word_t          mem [DEPTH];
    logic [AW-1:0]  wp_q, rp_q;
    logic [CW-1:0]  cnt_q;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp_q] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_en) wp_q <= step(wp_q);
            if (rd_en) rp_q <= step(rp_q);
            cnt_q <= cnt_q + CW'(wr_en) - CW'(rd_en);
        end
    end

    assign rd_data = mem[rp_q];
    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));

    // R6: the controller never pops a word that is not there
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> !empty);

endmodule

// File: rtl/mesh_rtr_inctl.sv
module mesh_rtr_inctl
    import mesh_rtr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  word_t            head,
    input  logic             empty,
    input  coord_t           my_x,
    input  coord_t           my_y,
    input  logic [NPORT-1:0] wall_ok,
    input  logic             gnt,
    input  logic             dst_rdy,
    output logic [NPORT-1:0] want,
    output port_e            dir,
    output logic             tail,
    output logic             pop,
    output logic             drop_hdr
);
    ictl_e st_q, st_d;
    port_e dir_q, dir_d;
    len_t  rem_q, rem_d;
    hdr_t  hdr;
    port_e rdir;
    logic  fire;
    logic  unused_hdr_bits;

    assign hdr             = hdr_t'(head);
    assign rdir            = xy_route(hdr, my_x, my_y);
    assign unused_hdr_bits = ^{hdr.tag, hdr.rsv};

    always_comb begin
        st_d     = st_q;
        dir_d    = dir_q;
        rem_d    = rem_q;
        want     = '0;
        dir      = dir_q;
        tail     = 1'b0;
        pop      = 1'b0;
        drop_hdr = 1'b0;
        fire     = 1'b0;
        case (st_q)
            S_IDLE: begin
                if (!empty) begin
                    dir = rdir;
                    if (wall_ok[rdir]) begin
                        want[rdir] = 1'b1;
                        tail       = (hdr.len == '0);
                        fire       = gnt && dst_rdy;
                        pop        = fire;
                        if (fire && hdr.len != '0) begin
                            st_d  = S_FWD;
                            dir_d = rdir;
                            rem_d = hdr.len;
                        end
                    end else begin
                        // forbidden output: discard header, then the body
                        pop      = 1'b1;
                        drop_hdr = 1'b1;
                        if (hdr.len != '0) begin
                            st_d  = S_DROP;
                            rem_d = hdr.len;
                        end
                    end
                end
            end
            S_FWD: begin
                want[dir_q] = 1'b1;
                tail        = (rem_q == len_t'(1));
                fire        = gnt && !empty && dst_rdy;
                pop         = fire;
                if (fire) begin
                    rem_d = rem_q - len_t'(1);
                    if (rem_q == len_t'(1)) st_d = S_IDLE;
                end
            end
            S_DROP: begin
                pop = !empty;
                if (!empty) begin
                    rem_d = rem_q - len_t'(1);
                    if (rem_q == len_t'(1)) st_d = S_IDLE;
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= S_IDLE;
            dir_q <= P_LOCAL;
            rem_q <= '0;
        end else begin
            st_q  <= st_d;
            dir_q <= dir_d;
            rem_q <= rem_d;
        end
    end

    // R8: a packet being discarded never bids for an output
    a_r8_drop_silent: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_DROP) |-> (want == '0));

endmodule

// File: rtl/mesh_rtr_arb.sv
module mesh_rtr_arb
    import mesh_rtr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] want,
    input  logic [NPORT-1:0] avail,
    input  logic [NPORT-1:0] last_word,
    input  logic             out_rdy,
    output logic [NPORT-1:0] grant,
    output logic             ovalid
);
    logic             locked_q;
    logic [NPORT-1:0] owner_q;
    logic [PW-1:0]    ptr_q;
    logic             xfer;
    logic             is_tail;

    assign grant   = locked_q ? owner_q : rr_pick(want, ptr_q);
    assign ovalid  = |(grant & avail);
    assign xfer    = ovalid && out_rdy;
    assign is_tail = |(grant & last_word);

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b0;
            owner_q  <= '0;
            ptr_q    <= PW'(NPORT - 1);
        end else if (xfer) begin
            if (is_tail) begin
                locked_q <= 1'b0;
                ptr_q    <= oh_index(grant);
            end else begin
                locked_q <= 1'b1;
                owner_q  <= grant;
            end
        end
    end

    // R7: at most one input drives an output
    a_r7_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R7: a free output is only given to an input asking for it
    a_r7_grant_wanted: assert property (@(posedge clk) disable iff (rst)
        !locked_q |-> ((grant & ~want) == '0));

    // R5: after a non-final word the same input keeps the output
    a_r5_wormhole_hold: assert property (@(posedge clk) disable iff (rst)
        (xfer && !is_tail) |=> (grant == $past(grant)));

endmodule

// File: rtl/mesh_router.sv
module mesh_router
    import mesh_rtr_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [COORD_W-1:0]        tile_x,
    input  logic [COORD_W-1:0]        tile_y,
    input  logic [NPORT-1:0]          hw_mask,
    input  logic [NPORT-1:0]          in_valid,
    input  logic [NPORT*WORD_W-1:0]   in_data,
    output logic [NPORT-1:0]          in_ready,
    output logic [NPORT-1:0]          out_valid,
    output logic [NPORT*WORD_W-1:0]   out_data,
    input  logic [NPORT-1:0]          out_ready,
    output logic                      hw_irq,
    output logic [WORD_W-1:0]         hw_hdr,
    output logic [PW-1:0]             hw_src
);
    word_t            head     [NPORT];
    word_t            odata    [NPORT];
    port_e            dir      [NPORT];
    logic [NPORT-1:0] want_io  [NPORT];
    logic [NPORT-1:0] want_oi  [NPORT];
    logic [NPORT-1:0] grant_oi [NPORT];
    logic [NPORT-1:0] empty, full, wr_en, pop, tail, drop_hdr, gnt_in;

    assign in_ready = ~full;

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        assign wr_en[i]  = in_valid[i] & ~full[i];
        assign gnt_in[i] = grant_oi[dir[i]][i];

        mesh_rtr_fifo #(.DEPTH(QDEPTH)) u_q (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en[i]),
            .wr_data (in_data[i*WORD_W +: WORD_W]),
            .rd_en   (pop[i]),
            .rd_data (head[i]),
            .empty   (empty[i]),
            .full    (full[i])
        );

        mesh_rtr_inctl u_ctl (
            .clk      (clk),
            .rst      (rst),
            .head     (head[i]),
            .empty    (empty[i]),
            .my_x     (tile_x),
            .my_y     (tile_y),
            .wall_ok  (hw_mask),
            .gnt      (gnt_in[i]),
            .dst_rdy  (out_ready[dir[i]]),
            .want     (want_io[i]),
            .dir      (dir[i]),
            .tail     (tail[i]),
            .pop      (pop[i]),
            .drop_hdr (drop_hdr[i])
        );
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        always_comb begin
            for (int i = 0; i < NPORT; i++) want_oi[o][i] = want_io[i][o];
        end

        mesh_rtr_arb u_arb (
            .clk       (clk),
            .rst       (rst),
            .want      (want_oi[o]),
            .avail     (~empty),
            .last_word (tail),
            .out_rdy   (out_ready[o]),
            .grant     (grant_oi[o]),
            .ovalid    (out_valid[o])
        );

        always_comb begin
            odata[o] = '0;
            for (int i = 0; i < NPORT; i++) begin
                if (grant_oi[o][i]) odata[o] = odata[o] | head[i];
            end
        end

        assign out_data[o*WORD_W +: WORD_W] = odata[o];
    end

    // Hardwall report: lowest input index wins if several drop together
    always_ff @(posedge clk) begin
        if (rst) begin
            hw_irq <= 1'b0;
            hw_hdr <= '0;
            hw_src <= '0;
        end else begin
            hw_irq <= |drop_hdr;
            for (int i = NPORT - 1; i >= 0; i--) begin
                if (drop_hdr[i]) begin
                    hw_hdr <= head[i];
                    hw_src <= PW'(i);
                end
            end
        end
    end

endmodule

// File: tb/tb_mesh_router.sv
module tb_mesh_router;
    import mesh_rtr_pkg::*;

    localparam int N = 5;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic [3:0]    tile_x = 4'd5;
    logic [3:0]    tile_y = 4'd5;
    logic [N-1:0]  hw_mask;
    logic [N-1:0]  in_valid;
    logic [N*W-1:0] in_data;
    logic [N-1:0]  in_ready;
    logic [N-1:0]  out_valid;
    logic [N*W-1:0] out_data;
    logic [N-1:0]  out_ready;
    logic          hw_irq;
    logic [W-1:0]  hw_hdr;
    logic [2:0]    hw_src;

    always #5 clk = ~clk;

    mesh_router #(.QDEPTH(4)) dut (
        .clk(clk), .rst(rst), .tile_x(tile_x), .tile_y(tile_y),
        .hw_mask(hw_mask), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .hw_irq(hw_irq), .hw_hdr(hw_hdr), .hw_src(hw_src)
    );

    int checks = 0;
    int fails  = 0;
    logic [31:0] srcq [N][$];
    logic [31:0] expq [N][N][$];
    logic [31:0] blkq [$];
    int          rrlog [$];
    bit          rr_en = 1'b0;
    int          rdy_mode = 0;
    bit          open_pkt [N];
    int          open_src [N];
    int          rem [N];
    logic [N-1:0] rdy_snap;
    int          pkt_id = 0;
    int          seq = 0;
    int          irq_cnt = 0;
    logic [31:0] last_blk = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // expected output per R3/R4, from the R2 field positions
    function automatic int ref_route(input logic [31:0] h);
        int dx, dy;
        dx = int'(h[19:16]);
        dy = int'(h[23:20]);
        if (dx > int'(tile_x)) return 2;
        if (dx < int'(tile_x)) return 4;
        if (dy > int'(tile_y)) return 1;
        if (dy < int'(tile_y)) return 3;
        return 0;
    endfunction

    task automatic send(input int s, input int dx, input int dy, input int len, input int rsv);
        logic [31:0] h, w;
        int o;
        h = {3'(s), 5'(pkt_id), 4'(dy), 4'(dx), 8'(rsv), 8'(len)};
        pkt_id++;
        o = ref_route(h);
        srcq[s].push_back(h);
        if (hw_mask[o]) expq[s][o].push_back(h);
        else begin
            blkq.push_back(h);
            last_blk = h;
        end
        for (int k = 0; k < len; k++) begin
            w = {3'(s), 29'(seq)};
            seq++;
            srcq[s].push_back(w);
            if (hw_mask[o]) expq[s][o].push_back(w);
        end
    endtask

    function automatic int pending();
        int t;
        t = blkq.size();
        for (int a = 0; a < N; a++) begin
            t += srcq[a].size();
            for (int b = 0; b < N; b++) t += expq[a][b].size();
        end
        return t;
    endfunction

    task automatic drain(input string req);
        int t;
        t = 0;
        while (pending() != 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        chk(pending() == 0, req, "all expected words delivered", 32'(pending()), 32'd0);
    endtask

    // input and output-ready driver
    initial begin
        in_valid  = '0;
        in_data   = '0;
        out_ready = '0;
        rdy_snap  = '0;
        forever begin
            @(negedge clk);
            for (int p = 0; p < N; p++) begin
                if (in_valid[p] && rdy_snap[p]) void'(srcq[p].pop_front());
                if (srcq[p].size() > 0) begin
                    in_valid[p]        = 1'b1;
                    in_data[p*W +: W]  = srcq[p][0];
                end else begin
                    in_valid[p] = 1'b0;
                end
            end
            rdy_snap = in_ready;
            for (int o = 0; o < N; o++) begin
                if (rdy_mode == 0)      out_ready[o] = 1'b1;
                else if (rdy_mode == 1) out_ready[o] = (($urandom % 3) != 0);
                else                    out_ready[o] = 1'b0;
            end
        end
    end

    // reference scoreboard, evaluated every cycle
    initial begin
        for (int o = 0; o < N; o++) begin
            open_pkt[o] = 1'b0;
            open_src[o] = 0;
            rem[o]      = 0;
        end
        forever begin
            @(negedge clk);
            #1;
            if (!rst) begin
                for (int o = 0; o < N; o++) begin
                    if (out_valid[o] && out_ready[o]) begin
                        logic [31:0] w;
                        int s;
                        w = out_data[o*W +: W];
                        s = int'(w[31:29]);
                        if (open_pkt[o])
                            chk(s == open_src[o], "R5", "packet interleaved", 32'(s), 32'(open_src[o]));
                        if (s >= N || expq[s][o].size() == 0) begin
                            chk(1'b0, "R3/R4/R8", "unexpected word on output", w, 32'(o));
                        end else begin
                            chk(w == expq[s][o][0], "R5", "word content/order", w, expq[s][o][0]);
                            void'(expq[s][o].pop_front());
                        end
                        if (!open_pkt[o]) begin
                            if (rr_en && o == 0) rrlog.push_back(s);
                            if (w[7:0] != 8'd0) begin
                                open_pkt[o] = 1'b1;
                                open_src[o] = s;
                                rem[o]      = int'(w[7:0]);
                            end
                        end else begin
                            rem[o]--;
                            if (rem[o] == 0) open_pkt[o] = 1'b0;
                        end
                    end
                end
                if (hw_irq) begin
                    irq_cnt++;
                    if (blkq.size() == 0) begin
                        chk(1'b0, "R9", "interrupt without blocked packet", hw_hdr, 32'd0);
                    end else begin
                        chk(hw_hdr == blkq[0], "R9", "status header", hw_hdr, blkq[0]);
                        chk(hw_src == blkq[0][31:29], "R9", "status source", 32'(hw_src), 32'(blkq[0][31:29]));
                        void'(blkq.pop_front());
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired act=%0d exp=%0d", pending(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst     = 1'b1;
        hw_mask = 5'b11111;
        repeat (3) @(negedge clk);
        #1;
        chk(in_ready == 5'b11111, "R1", "in_ready in reset", 32'(in_ready), 32'h1f);
        chk(out_valid == 5'b00000, "R1", "out_valid in reset", 32'(out_valid), 32'h0);
        chk(hw_irq == 1'b0, "R1", "hw_irq in reset", 32'(hw_irq), 32'h0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 R3 R4: every source to a 3x3 neighbourhood, reserved bits varied
        rdy_mode = 0;
        for (int s = 0; s < N; s++)
            for (int dx = 4; dx <= 6; dx++)
                for (int dy = 4; dy <= 6; dy++)
                    send(s, dx, dy, (dx + dy + s) % 4, s * 51 + dx);
        drain("R3");
        // X first: diagonal targets must leave east/west, never north/south
        send(0, 9, 12, 2, 0);
        send(0, 1, 0, 1, 255);
        drain("R4");

        // R6: outputs held, queue of north input fills
        rdy_mode = 2;
        send(1, 5, 5, 7, 0);
        repeat (12) @(negedge clk);
        #1;
        chk(in_ready[1] == 1'b0, "R6", "full queue deasserts ready", 32'(in_ready[1]), 32'd0);
        chk(out_valid[0] == 1'b1, "R6", "header offered while stalled", 32'(out_valid[0]), 32'd1);
        rdy_mode = 0;
        drain("R6");

        // R5 R6: long packets under random output stalls
        rdy_mode = 1;
        for (int r = 0; r < 6; r++)
            for (int s = 0; s < N; s++)
                send(s, (s * 3 + r) % 10, (r * 7 + s) % 10, 3 + ((r + s) % 10), 0);
        drain("R5");
        rdy_mode = 0;

        // R7: two inputs loaded while local output is held
        rdy_mode = 2;
        for (int k = 0; k < 4; k++) begin
            send(1, 5, 5, 0, 0);
            send(3, 5, 5, 0, 0);
        end
        repeat (10) @(negedge clk);
        rrlog.delete();
        rr_en    = 1'b1;
        rdy_mode = 0;
        drain("R7");
        rr_en = 1'b0;
        chk(rrlog.size() == 8, "R7", "contended headers seen", 32'(rrlog.size()), 32'd8);
        for (int k = 1; k < rrlog.size(); k++)
            chk(rrlog[k] != rrlog[k-1], "R7", "round-robin alternation", 32'(rrlog[k]), 32'(rrlog[k-1]));

        // R8 R9 R10: east output forbidden
        irq_cnt = 0;
        hw_mask = 5'b11011;
        @(negedge clk);
        send(0, 7, 5, 3, 0);
        send(0, 5, 7, 2, 0);
        drain("R10");
        chk(hw_hdr == last_blk, "R9", "status held after drain", hw_hdr, last_blk);
        send(4, 9, 2, 0, 0);
        drain("R8");
        // local output forbidden
        hw_mask = 5'b11110;
        @(negedge clk);
        send(1, 5, 5, 2, 0);
        send(1, 5, 3, 1, 0);
        drain("R10");
        repeat (5) @(negedge clk);
        chk(irq_cnt == 3, "R9", "one pulse per blocked packet", 32'(irq_cnt), 32'd3);
        chk(hw_src == 3'd1, "R9", "last blocked source", 32'(hw_src), 32'd1);
        chk(hw_hdr == last_blk, "R9", "last blocked header", hw_hdr, last_blk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule